// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-line programmable interrupt controller. A host writes single bytes to one of two ports, selected by a one-bit offset: offset 0 is the command port and offset 1 is the data port. The block sorts command-port bytes into a start-of-initialization word, an end-of-interrupt command or a read-select command. A small state machine then takes the following data-port bytes as the vector base, the cascade byte and the mode byte, skipping the ones the first word said are absent. Outside an initialization sequence, a data-port byte loads the line mask.

The decoder holds the configuration (trigger mode, single or cascade operation, vector base, cascade byte, automatic end of interrupt, mask) as plain output wires for the neighbouring priority unit. It gives that unit a one-cycle end-of-interrupt strobe with a line index, and it answers reads with the request or in-service register that the unit supplies, or with the mask. With the parameter `SLAVE_ROLE` at 0 the cascade byte is stored whole, as a map of lines with a slave behind them. With `SLAVE_ROLE` at 1 only its low three bits are kept, as the slave identity. Rotation, priority-setting and special-mask commands are accepted and do nothing.

The sequencer has four states. `SEQ_IDLE` is the reset state, where data bytes load the mask. `SEQ_WANT_VEC` waits for the vector byte. `SEQ_WANT_CASC` waits for the cascade byte. `SEQ_WANT_MODE` waits for the mode byte. The transitions are these. A start word moves any state to `SEQ_WANT_VEC`. A data byte in `SEQ_WANT_VEC` goes to `SEQ_WANT_CASC` in cascade mode; in single mode it goes to `SEQ_WANT_MODE` if a mode byte was requested and to `SEQ_IDLE` if not. A data byte in `SEQ_WANT_CASC` goes to `SEQ_WANT_MODE` or `SEQ_IDLE` on the same request flag. A data byte in `SEQ_WANT_MODE` goes to `SEQ_IDLE`.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the mask is 0x00, automatic end of interrupt is off, no strobe is active, command-port reads return the request register, and the sequencer is idle, so the first data-port write loads the mask.
- R2: A command-port write with bit 4 set is the start word. Bit 3 gives edge (1) or level (0) triggering, bit 1 = 1 gives single mode and 0 gives cascade mode, and bit 0 = 1 requests a mode byte. The start word also turns automatic end of interrupt off.
- R3: The first data byte after a start word sets the vector base to its bits 7:3. Its bits 2:0 are ignored, and the mask is not changed.
- R4: In cascade mode the second data byte after the start word is stored as the cascade byte. In single mode no cascade byte is taken.
- R5: A mode byte is taken only when the start word requested one, and its bit 1 turns automatic end of interrupt on (1) or off (0). The data byte after the last expected byte loads the mask.
- R6: When the sequencer is idle, a data-port write loads all eight mask bits. A data-port read returns the mask.
- R7: A command-port write with bits 4:3 = 00 and bits 7:5 = 001 raises the strobe in the next cycle, naming the highest set bit of the in-service register. If no bit is set, no strobe is raised.
- R8: A command-port write with bits 4:3 = 00 and bits 7:5 = 011 raises the strobe in the next cycle, naming the line in bits 2:0.
- R9: Command-port writes with bits 4:3 = 00 and any other code in bits 7:5 raise no strobe and change no configuration output.
- R10: A command-port write with bits 4:3 = 01 selects what command-port reads return: bit 0 = 1 gives the request register and 0 gives the in-service register.
- R11: Each end-of-interrupt command gives a strobe exactly one cycle long.
- R12: A start word that arrives while a sequence is still open restarts the sequence from the vector byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 1 | Port select: 0 command, 1 data |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the port selected by addr |
| irr_in | input | 8 | Request register from the priority unit |
| isr_in | input | 8 | In-service register from the priority unit |
| trig_edge | output | 1 | Edge triggering selected |
| single_mode | output | 1 | Single mode (no cascade) |
| vec_base | output | 5 | Vector base, the upper five vector bits |
| casc_cfg | output | 8 | Slave map (master) or slave identity (slave) |
| auto_eoi | output | 1 | Automatic end of interrupt enabled |
| irq_mask | output | 8 | Line mask |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_line | output | 3 | Line index carried by the strobe |

## Verification
The hardest situation to reach from the ports is a start word landing in the middle of an open sequence. If the restart is missed, later data bytes go to the wrong field, and the mismatch only shows one or two writes later, when the mask or mode output has the wrong value. The stimulus begins a cascade sequence with a mode byte, abandons it after the vector byte, and sends a fresh start word. It then follows every later byte to its field, and finally proves the sequencer is idle by loading the mask. Sweeps over all vector bases, all mask values, all in-service patterns and all subcommand codes cover the rest, with expected values worked out arithmetically.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WANT_VEC,
        SEQ_WANT_CASC,
        SEQ_WANT_MODE
    } seq_state_t;

    // subcommand codes in bits 7:5 of a command-2 byte
    localparam logic [2:0] OP_EOI_ANY  = 3'b001;
    localparam logic [2:0] OP_EOI_LINE = 3'b011;

    // command class from bits 4:3 of a command-port byte
    typedef enum logic [1:0] {
        CW_CMD2  = 2'b00,
        CW_CMD3  = 2'b01,
        CW_START = 2'b10
    } cmd_kind_t;

    function automatic cmd_kind_t classify(input logic [7:0] b);
        if (b[4])
            return CW_START;
        else if (b[3])
            return CW_CMD3;
        else
            return CW_CMD2;
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic data_wr,
    input  logic single_q,
    input  logic want_mode_q,
    output logic ld_vec,
    output logic ld_casc,
    output logic ld_mode,
    output logic ld_mask
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start_wr) begin
            state_d = SEQ_WANT_VEC;
        end else if (data_wr) begin
            unique case (state_q)
                SEQ_IDLE:      state_d = SEQ_IDLE;
                SEQ_WANT_VEC:  state_d = !single_q ? SEQ_WANT_CASC
                                       : (want_mode_q ? SEQ_WANT_MODE : SEQ_IDLE);
                SEQ_WANT_CASC: state_d = want_mode_q ? SEQ_WANT_MODE : SEQ_IDLE;
                SEQ_WANT_MODE: state_d = SEQ_IDLE;
                default:       state_d = SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_vec  = 1'b0;
        ld_casc = 1'b0;
        ld_mode = 1'b0;
        ld_mask = 1'b0;
        if (data_wr) begin
            unique case (state_q)
                SEQ_IDLE:      ld_mask = 1'b1;
                SEQ_WANT_VEC:  ld_vec  = 1'b1;
                SEQ_WANT_CASC: ld_casc = 1'b1;
                SEQ_WANT_MODE: ld_mode = 1'b1;
                default:       ld_mask = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pic_eoi_gen.sv
module pic_eoi_gen #(
    parameter int LINES = 8,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_any,
    input  logic             fire_line,
    input  logic [IDXW-1:0]  line_sel,
    input  logic [LINES-1:0] isr,
    output logic             eoi_valid,
    output logic [IDXW-1:0]  eoi_line
);

    logic [IDXW-1:0] top_idx;
    logic            any_set;

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (isr[i])
                top_idx = IDXW'(i);
        end
        any_set = |isr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_valid <= 1'b0;
            eoi_line  <= '0;
        end else begin
            eoi_valid <= fire_line || (fire_any && any_set);
            if (fire_line)
                eoi_line <= line_sel;
            else if (fire_any && any_set)
                eoi_line <= top_idx;
        end
    end

endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import pic_cmd_pkg::*;
#(
    parameter int DW         = 8,
    parameter bit SLAVE_ROLE = 1'b0,
    localparam int IDXW = $clog2(DW),
    localparam int VBW  = DW - IDXW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   irr_in,
    input  logic [DW-1:0]   isr_in,
    output logic            trig_edge,
    output logic            single_mode,
    output logic [VBW-1:0]  vec_base,
    output logic [DW-1:0]   casc_cfg,
    output logic            auto_eoi,
    output logic [DW-1:0]   irq_mask,
    output logic            eoi_valid,
    output logic [IDXW-1:0] eoi_line
);

    logic      cmd_wr, data_wr;
    cmd_kind_t kind;
    logic      start_wr, cmd2_wr, cmd3_wr;
    logic      ld_vec, ld_casc, ld_mode, ld_mask;
    logic      want_mode_q, rd_irr_q;
    logic [DW-1:0] casc_next;

    assign cmd_wr   = wr_en && !addr;
    assign data_wr  = wr_en && addr;
    assign kind     = classify(wdata);
    assign start_wr = cmd_wr && (kind == CW_START);
    assign cmd2_wr  = cmd_wr && (kind == CW_CMD2);
    assign cmd3_wr  = cmd_wr && (kind == CW_CMD3);

    pic_init_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .data_wr     (data_wr),
        .single_q    (single_mode),
        .want_mode_q (want_mode_q),
        .ld_vec      (ld_vec),
        .ld_casc     (ld_casc),
        .ld_mode     (ld_mode),
        .ld_mask     (ld_mask)
    );

    pic_eoi_gen #(.LINES(DW)) u_eoi (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_any  (cmd2_wr && wdata[7:5] == OP_EOI_ANY),
        .fire_line (cmd2_wr && wdata[7:5] == OP_EOI_LINE),
        .line_sel  (wdata[IDXW-1:0]),
        .isr       (isr_in),
        .eoi_valid (eoi_valid),
        .eoi_line  (eoi_line)
    );

    generate
        if (SLAVE_ROLE) begin : g_slave_id
            assign casc_next = {{(DW-IDXW){1'b0}}, wdata[IDXW-1:0]};
        end else begin : g_master_map
            assign casc_next = wdata;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_edge   <= 1'b0;
            single_mode <= 1'b0;
            want_mode_q <= 1'b0;
            vec_base    <= '0;
            casc_cfg    <= '0;
            auto_eoi    <= 1'b0;
            irq_mask    <= '0;
            rd_irr_q    <= 1'b1;
        end else begin
            if (start_wr) begin
                trig_edge   <= wdata[3];
                single_mode <= wdata[1];
                want_mode_q <= wdata[0];
                auto_eoi    <= 1'b0;
            end
            if (cmd3_wr)
                rd_irr_q <= wdata[0];
            if (ld_vec)
                vec_base <= wdata[DW-1:IDXW];
            if (ld_casc)
                casc_cfg <= casc_next;
            if (ld_mode)
                auto_eoi <= wdata[1];
            if (ld_mask)
                irq_mask <= wdata;
        end
    end

    assign rdata = addr ? irq_mask : (rd_irr_q ? irr_in : isr_in);

endmodule

module pic_cmd_decoder_chk #(
    parameter int DW = 8,
    localparam int IDXW = $clog2(DW),
    localparam int VBW  = DW - IDXW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            addr,
    input logic [DW-1:0]   wdata,
    input logic [VBW-1:0]  vec_base,
    input logic [DW-1:0]   irq_mask,
    input logic            eoi_valid,
    input logic [IDXW-1:0] eoi_line
);

    // R6
    mask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_mask) |-> $past(wr_en && addr));

    // R3
    vec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vec_base) |-> $past(wr_en && addr));

    // R7
    eoi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(wr_en && !addr && wdata[4:3] == 2'b00));

    // R8
    eoi_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:3] == 5'b01100)
        |=> (eoi_valid && eoi_line == $past(wdata[IDXW-1:0])));

    // R9
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:3] == 5'b01000) |=> !eoi_valid);

    // R11
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> !eoi_valid);

endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .vec_base  (vec_base),
    .irq_mask  (irq_mask),
    .eoi_valid (eoi_valid),
    .eoi_line  (eoi_line)
);

// File: tb/pic_cmd_decoder_tb.sv
module pic_cmd_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irr_in = 8'h00;
    logic [7:0] isr_in = 8'h00;
    logic       trig_edge, single_mode, auto_eoi, eoi_valid;
    logic [4:0] vec_base;
    logic [7:0] casc_cfg, irq_mask;
    logic [2:0] eoi_line;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pic_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .trig_edge(trig_edge), .single_mode(single_mode), .vec_base(vec_base),
        .casc_cfg(casc_cfg), .auto_eoi(auto_eoi), .irq_mask(irq_mask),
        .eoi_valid(eoi_valid), .eoi_line(eoi_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    function automatic int top_bit(input logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irr_in = 8'h5A; isr_in = 8'hC3;

        // R1 reset state
        chk(irq_mask == 8'h00, "R1 mask", irq_mask, 8'h00);
        chk(auto_eoi == 1'b0, "R1 auto_eoi", auto_eoi, 0);
        chk(eoi_valid == 1'b0, "R1 strobe", eoi_valid, 0);
        rd(1'b0, v);
        chk(v == 8'h5A, "R1 read select", v, 8'h5A);
        wr(1'b1, 8'h81);
        chk(irq_mask == 8'h81, "R1 idle mask load", irq_mask, 8'h81);

        // R6 mask sweep plus data-port read
        for (int m = 0; m < 256; m++) begin
            wr(1'b1, 8'(m));
            rd(1'b1, v);
            chk(irq_mask == 8'(m) && v == 8'(m), "R6 mask", v, m);
        end

        // R2 / R3 / R4 / R5 single mode, no mode byte; vector base sweep
        for (int b = 0; b < 32; b++) begin
            wr(1'b1, 8'h0F);
            wr(1'b0, 8'h1A);
            chk(trig_edge == 1'b1 && single_mode == 1'b1, "R2 start fields",
                {trig_edge, single_mode}, 3);
            wr(1'b1, {5'(b), 3'(b * 3)});
            chk(vec_base == 5'(b), "R3 vector base", vec_base, b);
            chk(irq_mask == 8'h0F, "R3 mask kept", irq_mask, 8'h0F);
            wr(1'b1, 8'(b + 8'h40));
            chk(irq_mask == 8'(b + 8'h40) && casc_cfg == 8'h00, "R4 single skips cascade",
                irq_mask, b + 8'h40);
        end

        // R2 / R4 / R5 cascade with mode byte
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h11);
        chk(trig_edge == 1'b0 && single_mode == 1'b0, "R2 level cascade",
            {trig_edge, single_mode}, 0);
        wr(1'b1, 8'h47);
        chk(vec_base == 5'h08, "R3 vector", vec_base, 8);
        wr(1'b1, 8'hA5);
        chk(casc_cfg == 8'hA5 && irq_mask == 8'hFF, "R4 cascade byte", casc_cfg, 8'hA5);
        wr(1'b1, 8'h02);
        chk(auto_eoi == 1'b1 && irq_mask == 8'hFF, "R5 auto eoi on", auto_eoi, 1);
        wr(1'b1, 8'h3C);
        chk(irq_mask == 8'h3C, "R5 mask after sequence", irq_mask, 8'h3C);
        wr(1'b0, 8'h13);
        chk(auto_eoi == 1'b0, "R2 start clears auto eoi", auto_eoi, 0);
        wr(1'b1, 8'h20);
        chk(casc_cfg == 8'hA5, "R4 single keeps cascade", casc_cfg, 8'hA5);
        wr(1'b1, 8'h00);
        chk(auto_eoi == 1'b0 && irq_mask == 8'h3C, "R5 mode byte off", auto_eoi, 0);
        wr(1'b1, 8'h66);
        chk(irq_mask == 8'h66, "R5 idle again", irq_mask, 8'h66);

        // R12 restart mid-sequence
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h18);
        wr(1'b0, 8'h11);
        wr(1'b1, 8'hF0);
        chk(vec_base == 5'h1E, "R12 restart vector", vec_base, 5'h1E);
        wr(1'b1, 8'h5A);
        chk(casc_cfg == 8'h5A, "R12 restart cascade", casc_cfg, 8'h5A);
        wr(1'b1, 8'h02);
        chk(auto_eoi == 1'b1 && irq_mask == 8'h66, "R12 restart mode", auto_eoi, 1);
        wr(1'b1, 8'h99);
        chk(irq_mask == 8'h99, "R12 back to idle", irq_mask, 8'h99);

        // R7 non-specific EOI over every in-service pattern
        for (int s = 0; s < 256; s++) begin
            isr_in = 8'(s);
            wr(1'b0, 8'h20);
            if (s == 0)
                chk(eoi_valid == 1'b0, "R7 no strobe when empty", eoi_valid, 0);
            else
                chk(eoi_valid && eoi_line == 3'(top_bit(8'(s))), "R7 highest line",
                    eoi_line, top_bit(8'(s)));
            @(negedge clk);
            chk(eoi_valid == 1'b0, "R11 one cycle", eoi_valid, 0);
        end

        // R8 specific EOI on every line
        isr_in = 8'h00;
        for (int l = 0; l < 8; l++) begin
            wr(1'b0, 8'(8'h60 | l));
            chk(eoi_valid && eoi_line == 3'(l), "R8 named line", eoi_line, l);
            @(negedge clk);
            chk(eoi_valid == 1'b0, "R11 one cycle", eoi_valid, 0);
        end

        // R9 all other subcommand codes
        isr_in = 8'hFF;
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 3) continue;
            wr(1'b0, {3'(c), 2'b00, 3'(c + 2)});
            chk(eoi_valid == 1'b0, "R9 no strobe", eoi_valid, 0);
            chk(irq_mask == 8'h99 && vec_base == 5'h1E && casc_cfg == 8'h5A
                && auto_eoi == 1'b1 && trig_edge == 1'b0 && single_mode == 1'b0,
                "R9 config unchanged", irq_mask, 8'h99);
        end

        // R10 read select
        irr_in = 8'h3E; isr_in = 8'hB1;
        wr(1'b0, 8'h0A);
        rd(1'b0, v);
        chk(v == 8'hB1, "R10 in-service read", v, 8'hB1);
        wr(1'b0, 8'h0B);
        rd(1'b0, v);
        chk(v == 8'h3E, "R10 request read", v, 8'h3E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule